// File: doc/BRIEF.md
# Data-Ready Burst Status Controller

This block drives a single data-ready status line that a host watches to follow the acquisition engine of a sensing device. The line is low while a measurement burst runs and high between bursts and during idle time. Once a complete three-byte host exchange has finished, the line is pulled low. It stays low until the next burst completes. This lets the host see whether its exchanges are still in step with the acquisition cycle.

Every high-to-low transition of the line opens a short grace window, counted in microsecond ticks. If the host starts an exchange while that window is open, the line returns high and stays high until the exchange ends. A burst-inhibit output is held for that time so the acquisition engine postpones its next burst. Burst-inhibit is also raised for a fixed number of ticks after each burst completes. This keeps the inter-burst high pulse at its full width.

The acquisition engine and the serial exchange logic are outside this block. They report to it through single-cycle event pulses and one level input.

Top module: `drdy_status`

## Requirements
- R1: During and immediately after a synchronous reset, `drdy` is 1 and `burst_hold` is 0.
- R2: A cycle after `burst_active` is sampled high, `drdy` is 0, unless a grace exchange is in progress.
- R3: With no burst running, no grace exchange in progress, and no exchange completed since the last `burst_done`, `drdy` is 1.
- R4: A cycle after `xfer_done`, `drdy` is 0. It stays 0, including through later bursts, until a `burst_done` pulse clears the exchange record.
- R5: `burst_done` raises `burst_hold` on the next cycle. `burst_hold` then stays high until `HIGH_US` ticks have occurred, and falls on the cycle after the last of those ticks.
- R6: An `xfer_start` arriving while `drdy` is 0 and fewer than `GRACE_US` ticks have passed since `drdy` fell drives both `drdy` and `burst_hold` to 1 on the next cycle. Both stay 1 until `xfer_done`, whatever `burst_active` does and however many ticks pass.
- R7: An `xfer_start` arriving after `GRACE_US` ticks have passed since `drdy` fell has no effect on `drdy` or `burst_hold`.
- R8: `burst_hold` from a grace exchange falls one cycle after `xfer_done`. At the same time, `drdy` goes to 0.
- R9: The grace window restarts on every falling edge of `drdy`, including the fall that ends a grace exchange.
- R10: If `xfer_done` and `burst_done` arrive in the same cycle, the exchange is recorded and `drdy` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| burst_active | input | 1 | High while an acquisition burst runs |
| burst_done | input | 1 | One-cycle pulse when a burst completes |
| xfer_start | input | 1 | One-cycle pulse when a host exchange begins |
| xfer_done | input | 1 | One-cycle pulse when a three-byte exchange completes |
| drdy | output | 1 | Registered data-ready status line |
| burst_hold | output | 1 | Registered request to postpone the next burst |

## Verification
If the exchange record is wrong, `drdy` takes the wrong level one cycle after the `xfer_done` or `burst_done` pulse that should have changed it. A fault in the grace counter shows up only when an `xfer_start` lands near the edge of the window. For that reason the bench starts exchanges one tick inside the window and exactly at its end, including after a restart caused by an earlier grace exchange. A bad inter-burst counter moves the fall of `burst_hold` away from the cycle that follows the `HIGH_US`-th tick, so that cycle is sampled on both sides.

// File: rtl/drdy_pkg.sv
package drdy_pkg;
  // Width of a down-counter able to hold the value n.
  function automatic int unsigned span_bits(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/us_window.sv
module us_window #(
  parameter int unsigned SPAN = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic tick,
  output logic busy
);
  localparam int unsigned CW = drdy_pkg::span_bits(SPAN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CW'(SPAN);
    end else if (tick && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);

  // R5 / R9: the count never exceeds its span and falls by one per tick
  a_r5_span_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(SPAN));
  a_r9_tick_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && busy) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/exch_tracker.sv
module exch_tracker (
  input  logic clk,
  input  logic rst,
  input  logic xfer_start,
  input  logic xfer_done,
  input  logic burst_done,
  input  logic line_low,
  input  logic grace_open,
  output logic flag_nx,
  output logic hold_nx,
  output logic hold_q
);
  logic flag_q;

  // Exchange record: set by a finished exchange, cleared by a finished burst;
  // a simultaneous pair keeps the record set (R10).
  always_comb begin
    flag_nx = flag_q;
    if (burst_done) flag_nx = 1'b0;
    if (xfer_done)  flag_nx = 1'b1;
  end

  // Grace exchange: only an exchange opening while the line is low and the
  // grace window is still running takes hold of the line (R6, R7).
  always_comb begin
    hold_nx = hold_q;
    if (xfer_start && line_low && grace_open) hold_nx = 1'b1;
    if (xfer_done) hold_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      flag_q <= flag_nx;
      hold_q <= hold_nx;
    end
  end

  // R8: a grace exchange ends on the edge that samples xfer_done
  a_r8_hold_release: assert property (@(posedge clk) disable iff (rst)
    $past(xfer_done) |-> !hold_q);
endmodule

// File: rtl/drdy_status.sv
module drdy_status #(
  parameter int unsigned HIGH_US  = 500,
  parameter int unsigned GRACE_US = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_us,
  input  logic burst_active,
  input  logic burst_done,
  input  logic xfer_start,
  input  logic xfer_done,
  output logic drdy,
  output logic burst_hold
);
  logic flag_nx, hold_nx, grace_q;
  logic drdy_nx, fall, grace_open, win_busy;
  logic armed_q;

  exch_tracker u_track (
    .clk        (clk),
    .rst        (rst),
    .xfer_start (xfer_start),
    .xfer_done  (xfer_done),
    .burst_done (burst_done),
    .line_low   (!drdy),
    .grace_open (grace_open),
    .flag_nx    (flag_nx),
    .hold_nx    (hold_nx),
    .hold_q     (grace_q)
  );

  assign drdy_nx = hold_nx | (!burst_active && !flag_nx);
  assign fall    = drdy && !drdy_nx;

  us_window #(.SPAN(GRACE_US)) u_grace (
    .clk  (clk),
    .rst  (rst),
    .load (fall),
    .tick (tick_us),
    .busy (grace_open)
  );

  us_window #(.SPAN(HIGH_US)) u_gap (
    .clk  (clk),
    .rst  (rst),
    .load (burst_done),
    .tick (tick_us),
    .busy (win_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drdy       <= 1'b1;
      burst_hold <= 1'b0;
      armed_q    <= 1'b0;
    end else begin
      drdy       <= drdy_nx;
      burst_hold <= hold_nx | burst_done | win_busy;
      armed_q    <= 1'b1;
    end
  end

  a_r2_burst_low: assert property (@(posedge clk) disable iff (rst)
    (armed_q && $past(burst_active) && !grace_q) |-> !drdy);
  a_r4_exchange_low: assert property (@(posedge clk) disable iff (rst)
    (armed_q && $past(xfer_done)) |-> !drdy);
  a_r6_grace_high: assert property (@(posedge clk) disable iff (rst)
    grace_q |-> (drdy && burst_hold));
  a_r5_gap_hold: assert property (@(posedge clk) disable iff (rst)
    (armed_q && $past(burst_done)) |-> burst_hold);
endmodule

// File: tb/test_drdy_status.sv
module test_drdy_status;
  localparam int unsigned HIGH_US  = 500;
  localparam int unsigned GRACE_US = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_us = 1'b0, burst_active = 1'b0, burst_done = 1'b0;
  logic xfer_start = 1'b0, xfer_done = 1'b0;
  logic drdy, burst_hold;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  drdy_status #(.HIGH_US(HIGH_US), .GRACE_US(GRACE_US)) i_drdy_status (
    .clk(clk), .rst(rst), .tick_us(tick_us), .burst_active(burst_active),
    .burst_done(burst_done), .xfer_start(xfer_start), .xfer_done(xfer_done),
    .drdy(drdy), .burst_hold(burst_hold)
  );

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_us = 1'b1; step();
      tick_us = 1'b0; step();
    end
  endtask

  task automatic chk(string req, logic got, logic exp, string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic p_start();
    xfer_start = 1'b1; step(); xfer_start = 1'b0;
  endtask
  task automatic p_done();
    xfer_done = 1'b1; step(); xfer_done = 1'b0;
  endtask
  task automatic p_bdone();
    burst_done = 1'b1; step(); burst_done = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; step(3);
    chk("R1", drdy, 1'b1, "drdy in reset");
    chk("R1", burst_hold, 1'b0, "burst_hold in reset");
    rst = 1'b0; step();
    chk("R1", drdy, 1'b1, "drdy after reset");
    chk("R3", drdy, 1'b1, "idle high");
  endtask

  task automatic t_burst_gap();
    burst_active = 1'b1; step();
    chk("R2", drdy, 1'b0, "drdy during burst");
    burst_active = 1'b0;
    p_bdone();
    chk("R3", drdy, 1'b1, "drdy after burst");
    chk("R5", burst_hold, 1'b1, "hold after burst_done");
    ticks(HIGH_US - 1);
    chk("R5", burst_hold, 1'b1, "hold one tick before end");
    ticks(1);
    chk("R5", burst_hold, 1'b0, "hold after window");
  endtask

  task automatic t_exchange_low();
    p_done();
    chk("R4", drdy, 1'b0, "drdy after exchange");
    ticks(GRACE_US + 2);
    burst_active = 1'b1; step(2); burst_active = 1'b0; step();
    chk("R4", drdy, 1'b0, "drdy stays low across burst");
    p_bdone();
    chk("R4", drdy, 1'b1, "drdy back high after burst_done");
    ticks(HIGH_US);
  endtask

  task automatic t_grace_accept();
    burst_active = 1'b1; step();
    chk("R2", drdy, 1'b0, "drdy low at burst start");
    ticks(GRACE_US - 1);
    p_start();
    chk("R6", drdy, 1'b1, "drdy raised by grace exchange");
    chk("R6", burst_hold, 1'b1, "hold during grace exchange");
    ticks(GRACE_US + 10);
    chk("R6", drdy, 1'b1, "drdy held until done");
    chk("R6", burst_hold, 1'b1, "hold kept until done");
    p_done();
    chk("R8", burst_hold, 1'b0, "hold released after done");
    chk("R8", drdy, 1'b0, "drdy low after grace exchange");
    burst_active = 1'b0;
    p_bdone();
    ticks(HIGH_US);
    chk("R3", drdy, 1'b1, "idle high after cycle");
  endtask

  task automatic t_grace_expired();
    burst_active = 1'b1; step();
    ticks(GRACE_US);
    p_start();
    chk("R7", drdy, 1'b0, "late start leaves drdy low");
    chk("R7", burst_hold, 1'b0, "late start leaves hold low");
    burst_active = 1'b0;
    p_bdone();
    ticks(HIGH_US);
  endtask

  task automatic t_grace_restart();
    p_done();
    chk("R4", drdy, 1'b0, "drdy low on exchange");
    ticks(15);
    p_start();
    chk("R9", drdy, 1'b1, "first grace start accepted");
    p_done();
    chk("R9", drdy, 1'b0, "drdy falls again");
    ticks(GRACE_US - 1);
    p_start();
    chk("R9", drdy, 1'b1, "restarted window accepts start");
    p_done();
    p_bdone();
    chk("R3", drdy, 1'b1, "high after clearing burst_done");
    ticks(HIGH_US);
  endtask

  task automatic t_coincident();
    xfer_done = 1'b1; burst_done = 1'b1; step();
    xfer_done = 1'b0; burst_done = 1'b0;
    chk("R10", drdy, 1'b0, "exchange wins over burst_done");
    p_bdone();
    chk("R10", drdy, 1'b1, "later burst_done clears");
    ticks(HIGH_US);
  endtask

  initial begin
    t_reset();
    t_burst_gap();
    t_exchange_low();
    t_grace_accept();
    t_grace_expired();
    t_grace_restart();
    t_coincident();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(10 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule